// File: doc/BRIEF.md
# Software-generated interrupt dispatcher

The dispatcher takes a 64-bit software-generated-interrupt request from a requesting CPU. It turns that request into pending-set strobes for the CPUs the request selects. A request names the interrupt number and a routing mode. In targeted mode it also carries an affinity prefix (levels 3, 2 and 1) and a 16-bit list of level-0 values.

The block walks a table that holds the affinity of each CPU. It visits one CPU per clock in ascending index order and strobes the pending-set line of every CPU it selects. Broadcast mode selects every CPU except the requester. Targeted mode selects a CPU whose upper affinity matches the prefix and whose level-0 value indexes a set list bit. A working copy of the list loses each bit as it is consumed, and the walk stops as soon as that copy is empty. At the end the block raises a one-cycle done pulse. With it comes an update pulse, but only when at least one CPU was flagged. The requester's identity is not passed on with the pending state.

Requests arrive on a valid/ready handshake. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole walk, so the sender may hold its request, or withdraw it, until the block is idle again. The CPU affinity table is a plain input that must stay stable during a walk.

Top module: `sgi_dispatch`

## Requirements
- R1: The request word is decoded as follows: target list in bits 15:0, Aff1 in bits 23:16, interrupt number in bits 27:24, Aff2 in bits 39:32, routing mode in bit 40 (1 = broadcast), Aff3 in bits 55:48. `pend_id` carries the interrupt number whenever a strobe is high.
- R2: In broadcast mode every CPU except the one at index `req_src` is strobed, and the target list has no effect.
- R3: In targeted mode a CPU is strobed only if its Aff3, Aff2 and Aff1 all equal the requested values and the list bit indexed by its Aff0 is set.
- R4: In targeted mode a CPU whose Aff0 is 16 or more is never strobed.
- R5: CPUs are visited one per clock in ascending index order. At most one strobe is high per cycle, and each CPU is strobed at most once per request.
- R6: The walk ends at the last CPU index, or, in targeted mode, on the visit that empties the working list. Its length in cycles is the index of the last CPU visited plus one.
- R7: `done` pulses for one cycle, in the same cycle as the strobe of the final visit. `updated` pulses together with `done` exactly when at least one CPU was strobed.
- R8: A targeted request with an empty target list ends after one cycle with no strobe and no update pulse.
- R9: `req_ready` is low from acceptance until the walk ends. Requests offered in that time are not taken and do not change the walk.
- R10: After reset the block is idle: ready high, no strobes, no done, no update.
- R11: When two CPUs share one affinity, only the lowest-indexed one is strobed in targeted mode, because its visit consumes the list bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_word | input | 64 | Request word (layout in R1) |
| req_src | input | IDX_W | Index of the requesting CPU |
| cpu_aff | input | 32*NUM_CPU | Affinity table; CPU i in bits 32i+31:32i as {Aff3,Aff2,Aff1,Aff0} |
| busy | output | 1 | Walk in progress |
| pend_set | output | NUM_CPU | Per-CPU pending-set strobes |
| pend_id | output | 4 | Interrupt number for the strobes |
| done | output | 1 | Walk finished (one cycle) |
| updated | output | 1 | Walk finished and set at least one CPU pending |

## Verification
Damage to the working list shows up in two ways. A CPU may be strobed twice, or a duplicate-affinity CPU may be hit. Alternatively the walk may end early or late, which moves the `done` cycle. The bench compares the length of every walk with a model, so such errors surface within one request. A wrong visit index shows up at once as a strobe out of ascending order, or on the requester during a broadcast. A stale flag for an earlier hit appears as an `updated` pulse with no strobe behind it, at the end of the same walk.

// File: rtl/sgi_dispatch_pkg.sv
package sgi_dispatch_pkg;
  localparam int WORD_W = 64;
  localparam int LIST_W = 16;
  localparam int AFF_W  = 8;
  localparam int ID_W   = 4;
  localparam int SEL_W  = $clog2(LIST_W);
  localparam int CPU_AFF_W = 4 * AFF_W;

  // bit positions inside the request word
  localparam int POS_LIST = 0;
  localparam int POS_AFF1 = 16;
  localparam int POS_ID   = 24;
  localparam int POS_AFF2 = 32;
  localparam int POS_MODE = 40;
  localparam int POS_AFF3 = 48;

  typedef struct packed {
    logic [AFF_W-1:0]  aff3;
    logic [AFF_W-1:0]  aff2;
    logic [AFF_W-1:0]  aff1;
    logic              bcast;
    logic [ID_W-1:0]   intid;
    logic [LIST_W-1:0] tlist;
  } sgi_req_t;

  typedef struct packed {
    logic [AFF_W-1:0] aff3;
    logic [AFF_W-1:0] aff2;
    logic [AFF_W-1:0] aff1;
    logic [AFF_W-1:0] aff0;
  } cpu_aff_t;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_dispatch_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output sgi_req_t          req
);
  logic unused_bits;

  always_comb begin
    req.tlist = word[POS_LIST +: LIST_W];
    req.aff1  = word[POS_AFF1 +: AFF_W];
    req.intid = word[POS_ID   +: ID_W];
    req.aff2  = word[POS_AFF2 +: AFF_W];
    req.bcast = word[POS_MODE];
    req.aff3  = word[POS_AFF3 +: AFF_W];
  end

  assign unused_bits = ^{word[31:28], word[47:41], word[63:56]};
endmodule

// File: rtl/sgi_target_match.sv
module sgi_target_match
  import sgi_dispatch_pkg::*;
(
  input  sgi_req_t          req,
  input  logic [LIST_W-1:0] work_list,
  input  cpu_aff_t          aff,
  input  logic              is_src,
  output logic              hit,
  output logic [LIST_W-1:0] clr
);
  logic             prefix_eq;
  logic             aff0_ok;
  logic [SEL_W-1:0] sel;
  logic             tgt_hit;

  always_comb begin
    prefix_eq = (aff.aff3 == req.aff3) && (aff.aff2 == req.aff2) &&
                (aff.aff1 == req.aff1);
    aff0_ok   = aff.aff0 < AFF_W'(LIST_W);
    sel       = aff.aff0[SEL_W-1:0];
    tgt_hit   = prefix_eq && aff0_ok && work_list[sel];
    hit       = req.bcast ? !is_src : tgt_hit;
    clr       = '0;
    if (!req.bcast && tgt_hit) clr[sel] = 1'b1;
  end
endmodule

// File: rtl/sgi_walk_ctrl.sv
module sgi_walk_ctrl
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [LIST_W-1:0]             start_list,
  input  logic                          bcast,
  input  logic [NUM_CPU-1:0]            hit_vec,
  input  logic [NUM_CPU-1:0][LIST_W-1:0] clr_vec,
  output logic [LIST_W-1:0]             work_list,
  output logic                          busy,
  output logic [NUM_CPU-1:0]            strobe,
  output logic                          done,
  output logic                          updated
);
  typedef enum logic {ST_IDLE, ST_WALK} st_e;

  st_e                st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [LIST_W-1:0]  list_q;
  logic               any_q;
  logic               cur_hit;
  logic [LIST_W-1:0]  list_nx;
  logic               finish;
  logic [NUM_CPU-1:0] cur_sel;

  always_comb begin
    cur_hit = hit_vec[idx_q];
    list_nx = list_q & ~clr_vec[idx_q];
    finish  = (idx_q == IDX_W'(NUM_CPU - 1)) || (!bcast && list_nx == '0);
    cur_sel = '0;
    cur_sel[idx_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      list_q  <= '0;
      any_q   <= 1'b0;
      strobe  <= '0;
      done    <= 1'b0;
      updated <= 1'b0;
    end else begin
      strobe  <= '0;
      done    <= 1'b0;
      updated <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_WALK;
            idx_q  <= '0;
            list_q <= start_list;
            any_q  <= 1'b0;
          end
        end
        ST_WALK: begin
          strobe <= cur_hit ? cur_sel : '0;
          list_q <= list_nx;
          any_q  <= any_q | cur_hit;
          if (finish) begin
            st_q    <= ST_IDLE;
            done    <= 1'b1;
            updated <= any_q | cur_hit;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q == ST_WALK);
  assign work_list = list_q;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPU = 8,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [WORD_W-1:0]            req_word,
  input  logic [IDX_W-1:0]             req_src,
  input  logic [NUM_CPU*CPU_AFF_W-1:0] cpu_aff,
  output logic                         busy,
  output logic [NUM_CPU-1:0]           pend_set,
  output logic [ID_W-1:0]              pend_id,
  output logic                         done,
  output logic                         updated
);
  sgi_req_t                       dec;
  sgi_req_t                       req_q;
  logic [IDX_W-1:0]               src_q;
  logic                           accept;
  logic [LIST_W-1:0]              work_list;
  logic [NUM_CPU-1:0]             hit_vec;
  logic [NUM_CPU-1:0][LIST_W-1:0] clr_vec;

  sgi_req_decode u_dec (.word(req_word), .req(dec));

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      src_q <= '0;
    end else if (accept) begin
      req_q <= dec;
      src_q <= req_src;
    end
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    sgi_target_match u_match (
      .req      (req_q),
      .work_list(work_list),
      .aff      (cpu_aff_t'(cpu_aff[g*CPU_AFF_W +: CPU_AFF_W])),
      .is_src   (src_q == IDX_W'(g)),
      .hit      (hit_vec[g]),
      .clr      (clr_vec[g])
    );
  end

  sgi_walk_ctrl #(.NUM_CPU(NUM_CPU)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_list(dec.tlist),
    .bcast     (req_q.bcast),
    .hit_vec   (hit_vec),
    .clr_vec   (clr_vec),
    .work_list (work_list),
    .busy      (busy),
    .strobe    (pend_set),
    .done      (done),
    .updated   (updated)
  );

  assign pend_id = req_q.intid;
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CPU = 8,
  localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [63:0]        req_word,
  input logic [IDX_W-1:0]   req_src,
  input logic               busy,
  input logic [NUM_CPU-1:0] pend_set,
  input logic               done,
  input logic               updated
);
  logic             bc_q;
  logic [IDX_W-1:0] src_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q   <= 1'b0;
      src_q  <= '0;
      seen_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      bc_q   <= req_word[40];
      src_q  <= req_src;
      seen_q <= 1'b0;
    end else if (|pend_set) begin
      seen_q <= 1'b1;
    end
  end

  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_set));
  assert_strobe_from_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |-> $past(busy));
  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> (pend_set == '0));
  assert_skip_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_q && |pend_set) |-> !pend_set[src_q]);
  assert_update_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    updated |-> done);
  assert_update_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    updated |-> (seen_q || |pend_set));
  assert_done_ends_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_start_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_word (req_word),
  .req_src  (req_src),
  .busy     (busy),
  .pend_set (pend_set),
  .done     (done),
  .updated  (updated)
);

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [63:0]   req_word = '0;
  logic [IW-1:0] req_src = '0;
  logic [N*32-1:0] cpu_aff;
  logic          busy;
  logic [N-1:0]  pend_set;
  logic [3:0]    pend_id;
  logic          done;
  logic          updated;

  int checks = 0;
  int failures = 0;
  logic [7:0] a3 [N];
  logic [7:0] a2 [N];
  logic [7:0] a1 [N];
  logic [7:0] a0 [N];

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) cpu_aff[i*32 +: 32] = {a3[i], a2[i], a1[i], a0[i]};

  sgi_dispatch #(.NUM_CPU(N)) i_sgi_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_src(req_src), .cpu_aff(cpu_aff), .busy(busy),
    .pend_set(pend_set), .pend_id(pend_id), .done(done), .updated(updated));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] f3, input logic [7:0] f2,
                                     input logic [7:0] f1, input logic bc,
                                     input logic [3:0] id, input logic [15:0] lst);
    logic [63:0] w = '0;
    w[15:0] = lst; w[23:16] = f1; w[27:24] = id;
    w[39:32] = f2; w[40] = bc; w[55:48] = f3;
    return w;
  endfunction

  task automatic model(input logic [63:0] w, input int src,
                       output logic [N-1:0] m, output int visits);
    logic [15:0] lst = w[15:0];
    m = '0; visits = 0;
    for (int i = 0; i < N; i++) begin
      visits++;
      if (w[40]) begin
        if (i != src) m[i] = 1'b1;
      end else if (a3[i] == w[55:48] && a2[i] == w[39:32] && a1[i] == w[23:16] &&
                   a0[i] < 16 && lst[a0[i][3:0]]) begin
        m[i] = 1'b1;
        lst[a0[i][3:0]] = 1'b0;
      end
      if (!w[40] && lst == 0) break;
    end
  endtask

  task automatic run_req(input logic [63:0] w, input int src, input string tag,
                         input bit intrude);
    logic [N-1:0] em, acc;
    int ev, cyc, ns, last;
    bit ord_ok, id_ok, upd, got;
    model(w, src, em, ev);
    req_word = w; req_src = IW'(src); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      req_word = mk(0, 0, 0, 1'b1, 4'hF, 16'hFFFF); req_valid = 1'b1;
    end
    acc = '0; cyc = 0; ns = 0; last = -1; ord_ok = 1; id_ok = 1; upd = 0; got = 0;
    while (!got && cyc < 64) begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc <= 2) check("R9 ready low while busy", req_ready, 0);
      if (intrude && cyc == 2) req_valid = 1'b0;
      for (int i = 0; i < N; i++)
        if (pend_set[i]) begin
          ns++;
          if (i <= last) ord_ok = 0;
          last = i;
        end
      if (|pend_set && pend_id != w[27:24]) id_ok = 0;
      acc |= pend_set;
      if (done) begin got = 1; upd = updated; end
    end
    check({tag, " strobe set"}, acc, em);
    check("R6 walk length", cyc, ev);
    check("R7 update pulse", upd, em != 0);
    check("R5 one strobe per CPU", ns, $countones(em));
    check("R5 ascending order", ord_ok, 1);
    check("R1 interrupt number", id_ok, 1);
  endtask

  task automatic base_table();
    for (int i = 0; i < N; i++) begin
      a3[i] = 8'h01; a2[i] = 8'h02; a1[i] = (i < 4) ? 8'h10 : 8'h11; a0[i] = 8'(i % 4);
    end
    a0[7] = 8'd20;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] w;
    base_table();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", req_ready, 1);
    check("R10 idle after reset", busy, 0);
    check("R10 no strobe after reset", pend_set, 0);
    check("R10 no done after reset", {done, updated}, 0);

    run_req(mk(8'h01, 8'h02, 8'h10, 1'b1, 4'h5, 16'h0000), 3, "R2 broadcast", 0);
    run_req(mk(8'h01, 8'h02, 8'h10, 1'b1, 4'h6, 16'hFFFF), 0, "R2 broadcast list", 0);
    run_req(mk(8'h01, 8'h02, 8'h10, 1'b0, 4'h9, 16'h0005), 0, "R3 targeted", 0);
    run_req(mk(8'h01, 8'h02, 8'h11, 1'b0, 4'h2, 16'h0008), 0, "R3 targeted", 0);
    run_req(mk(8'h03, 8'h02, 8'h10, 1'b0, 4'h1, 16'h000F), 0, "R3 prefix mismatch", 0);
    run_req(mk(8'h01, 8'h02, 8'h10, 1'b0, 4'h7, 16'h0000), 0, "R8 empty list", 0);
    run_req(mk(8'h01, 8'h02, 8'h11, 1'b0, 4'h4, 16'h0010), 0, "R4 large aff0", 0);
    a0[6] = 8'd1;
    run_req(mk(8'h01, 8'h02, 8'h11, 1'b0, 4'hA, 16'h0002), 0, "R11 shared affinity", 0);
    base_table();
    run_req(mk(8'h01, 8'h02, 8'h11, 1'b0, 4'h3, 16'h0010), 0, "R9 busy ignore", 1);
    repeat (3) begin
      @(negedge clk);
      check("R9 no strobe after ignored request", pend_set, 0);
      check("R9 idle after ignored request", busy, 0);
    end

    void'($urandom(32'h5A17));
    for (int it = 0; it < 300; it++) begin
      if (it % 20 == 0)
        for (int i = 0; i < N; i++) begin
          a3[i] = 8'($urandom_range(0, 1)); a2[i] = 8'h00;
          a1[i] = 8'($urandom_range(0, 1)); a0[i] = 8'($urandom_range(0, 17));
        end
      w = mk(8'($urandom_range(0, 1)), 8'h00, 8'($urandom_range(0, 1)),
             $urandom_range(0, 3) == 0, 4'($urandom), 16'($urandom));
      w[63:56] = 8'($urandom); w[31:28] = 4'($urandom);
      run_req(w, $urandom_range(0, N - 1), w[40] ? "R2 random" : "R3 random", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule